// File: doc/BRIEF.md
# Clock burst sequence generator

This block drives one general-purpose digital output with a clock made of programmed segments. Each segment sets a half-period length, counted in system clock cycles, and a count of output periods. The block plays every segment for exactly that many full periods, then moves straight on to the next one. The result is a train of slower clocks, each with a set frequency and a set length.

Software first fills the segment table through a write port and sets how many entries a run uses. A start pulse then plays the entries in table order, beginning at entry 0. The busy flag stays high until the last period of the last entry has finished. Converting frequencies into half-period counts is left to the host.

Top module: `clk_burst_seq`

## Requirements
- R1: Reset, asynchronous and active low, forces busy and clk_out low, returns the block to idle and clears the entry-count register to 0. The table contents are not reset.
- R2: A write with tbl_we stores a half-period value and a period count at tbl_addr. A write with len_we sets the number of entries used to len_val, saturated at ENTRIES. A start pulse while that number is 0 leaves busy low.
- R3: A start sampled while idle, with a nonzero entry count, raises busy at that same clock edge. Playback begins at entry 0 with clk_out low.
- R4: For an entry with half-period value h and count n > 0, clk_out is low for h cycles and then high for h cycles. This low-high pair repeats exactly n times.
- R5: Entries play in ascending table order. There is no idle cycle between the end of one active entry and the start of the next, and every entry begins with its low half.
- R6: An entry whose count is 0 produces no period. It takes exactly one cycle with busy high and clk_out low, at its place in the order.
- R7: Busy falls on the same edge at which the high half of the final period ends. clk_out is low whenever busy is low.
- R8: A start pulse while busy is ignored. The running sequence keeps its timing and ends at its normal cycle.
- R9: A half-period value of 0 behaves exactly like a value of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Segment table write strobe |
| tbl_addr | input | IDX_W (6) | Entry address for the table write |
| tbl_half | input | HALF_W (16) | Half-period length in clock cycles |
| tbl_count | input | CNT_W (16) | Number of output periods for the entry |
| len_we | input | 1 | Entry-count register write strobe |
| len_val | input | LEN_W (7) | Number of entries to play |
| start | input | 1 | Start pulse; only acted on when idle |
| busy | output | 1 | High while a sequence is playing |
| clk_out | output | 1 | Generated burst clock |

## Verification
Two events can land on the same edge: the end of one segment's last high half, and the loading of the next entry's timer and count. When the next entry is empty, or past the end of the list, a skip or the end of the run takes the place of the load on that edge. The bench provokes these cases with back-to-back active entries, with empty entries in the middle and at the end, and with an empty entry 0. Every cycle of clk_out and busy is compared against a waveform that the bench builds from R4 to R6, so a gap or an overlap of a single cycle at any seam shows up as a mismatch. A start pulse in the middle of a run, and a reset during a run, cover the other collisions.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SKIP = 2'd2
  } seq_state_e;

  // Effective half-period: a programmed 0 counts as 1 cycle.
  function automatic logic [31:0] eff_half(input logic [31:0] raw);
    return (raw == 32'd0) ? 32'd1 : raw;
  endfunction

  // Timer reload value: the counter runs from eff-1 down to 0.
  function automatic logic [31:0] half_reload(input logic [31:0] raw);
    return eff_half(raw) - 32'd1;
  endfunction

  // Saturate a requested entry count at the table depth.
  function automatic logic [31:0] clamp_len(input logic [31:0] req, input logic [31:0] depth);
    return (req > depth) ? depth : req;
  endfunction

endpackage

// File: rtl/cbs_seg_table.sv
module cbs_seg_table #(
  parameter int ENTRIES = 64,
  parameter int HALF_W  = 16,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int WORD_W = HALF_W + CNT_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [HALF_W-1:0] wr_half,
  input  logic [CNT_W-1:0]  wr_cnt,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [HALF_W-1:0] rd_half,
  output logic [CNT_W-1:0]  rd_cnt
);

  logic [WORD_W-1:0] mem_q [ENTRIES];
  logic [WORD_W-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= {wr_half, wr_cnt};
    end
  end

  assign rd_word = mem_q[rd_addr];
  assign rd_half = rd_word[WORD_W-1:CNT_W];
  assign rd_cnt  = rd_word[CNT_W-1:0];

endmodule

// File: rtl/cbs_half_timer.sv
module cbs_half_timer #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HALF_W-1:0] half_raw,
  input  logic              run,
  output logic              expire
);

  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] reload_q;
  logic [HALF_W-1:0] reload_new;

  assign reload_new = HALF_W'(cbs_pkg::half_reload(32'(half_raw)));
  assign expire     = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (load) begin
      cnt_q    <= reload_new;
      reload_q <= reload_new;
    end else if (expire) begin
      cnt_q <= reload_q;
    end else if (run) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/cbs_sequencer.sv
module cbs_sequencer #(
  parameter int IDX_W  = 6,
  parameter int LEN_W  = 7,
  parameter int HALF_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len,
  input  logic [HALF_W-1:0] ent_half,
  input  logic [CNT_W-1:0]  ent_cnt,
  input  logic              expire,
  output logic [IDX_W-1:0]  rd_addr,
  output logic              tmr_load,
  output logic [HALF_W-1:0] tmr_half,
  output logic              tmr_run,
  output logic              busy,
  output logic              clk_out,
  output logic              seg_load,
  output logic              seq_done
);
  import cbs_pkg::*;

  seq_state_e       state_q;
  logic [LEN_W-1:0] idx_q;
  logic [CNT_W-1:0] left_q;
  logic             out_q;

  logic [LEN_W-1:0] cand;
  logic             seg_end;
  logic             examine;
  logic             in_range;
  logic             ent_active;

  // Entry under examination this cycle.
  always_comb begin
    unique case (state_q)
      ST_RUN:  cand = idx_q + LEN_W'(1);
      ST_SKIP: cand = idx_q;
      default: cand = '0;
    endcase
  end

  assign seg_end    = (state_q == ST_RUN) && expire && out_q && (left_q == CNT_W'(1));
  assign examine    = ((state_q == ST_IDLE) && start && (len != '0)) || seg_end || (state_q == ST_SKIP);
  assign in_range   = cand < len;
  assign ent_active = ent_cnt != '0;

  assign rd_addr  = cand[IDX_W-1:0];
  assign seg_load = examine && in_range && ent_active;
  assign seq_done = examine && !in_range;
  assign tmr_load = seg_load;
  assign tmr_half = ent_half;
  assign tmr_run  = state_q == ST_RUN;
  assign busy     = state_q != ST_IDLE;
  assign clk_out  = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      left_q  <= '0;
      out_q   <= 1'b0;
    end else if (examine) begin
      out_q <= 1'b0;
      if (!in_range) begin
        state_q <= ST_IDLE;
      end else if (ent_active) begin
        state_q <= ST_RUN;
        idx_q   <= cand;
        left_q  <= ent_cnt;
      end else begin
        state_q <= ST_SKIP;
        idx_q   <= cand + LEN_W'(1);
      end
    end else if ((state_q == ST_RUN) && expire) begin
      out_q <= ~out_q;
      if (out_q) begin
        left_q <= left_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/clk_burst_seq.sv
module clk_burst_seq #(
  parameter int ENTRIES = 64,
  parameter int HALF_W  = 16,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LEN_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [HALF_W-1:0] tbl_half,
  input  logic [CNT_W-1:0]  tbl_count,
  input  logic              len_we,
  input  logic [LEN_W-1:0]  len_val,
  input  logic              start,
  output logic              busy,
  output logic              clk_out
);

  logic [LEN_W-1:0]  len_q;
  logic [IDX_W-1:0]  rd_addr;
  logic [HALF_W-1:0] ent_half;
  logic [CNT_W-1:0]  ent_cnt;
  logic              tmr_load;
  logic [HALF_W-1:0] tmr_half;
  logic              tmr_run;
  logic              tmr_expire;
  logic              seg_load;
  logic              seq_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_we) begin
      len_q <= LEN_W'(cbs_pkg::clamp_len(32'(len_val), 32'(ENTRIES)));
    end
  end

  cbs_seg_table #(
    .ENTRIES(ENTRIES), .HALF_W(HALF_W), .CNT_W(CNT_W)
  ) i_table (
    .clk(clk), .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_half(tbl_half),
    .wr_cnt(tbl_count), .rd_addr(rd_addr), .rd_half(ent_half), .rd_cnt(ent_cnt)
  );

  cbs_half_timer #(.HALF_W(HALF_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .half_raw(tmr_half),
    .run(tmr_run), .expire(tmr_expire)
  );

  cbs_sequencer #(
    .IDX_W(IDX_W), .LEN_W(LEN_W), .HALF_W(HALF_W), .CNT_W(CNT_W)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len_q),
    .ent_half(ent_half), .ent_cnt(ent_cnt), .expire(tmr_expire),
    .rd_addr(rd_addr), .tmr_load(tmr_load), .tmr_half(tmr_half), .tmr_run(tmr_run),
    .busy(busy), .clk_out(clk_out), .seg_load(seg_load), .seq_done(seq_done)
  );

endmodule

// File: rtl/clk_burst_seq_chk.sv
module clk_burst_seq_chk #(
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             clk_out,
  input logic             expire,
  input logic             seg_load,
  input logic             seq_done,
  input logic [LEN_W-1:0] len_q
);

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !clk_out);

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (len_q != '0)) |=> busy);

  // R2
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (len_q == '0)) |=> !busy);

  // R5
  seg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_load |=> (busy && !clk_out));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !expire && !seg_load) |=> $stable(clk_out));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !seq_done) |=> busy);

  // R7
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (!busy && !clk_out));

endmodule

bind clk_burst_seq clk_burst_seq_chk #(.LEN_W(LEN_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .clk_out(clk_out),
  .expire(tmr_expire), .seg_load(seg_load), .seq_done(seq_done), .len_q(len_q)
);

// File: tb/test_clk_burst_seq.sv
module test_clk_burst_seq;

  localparam int ENTRIES = 64;
  localparam int HALF_W  = 16;
  localparam int CNT_W   = 16;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int LEN_W   = $clog2(ENTRIES + 1);

  // {half, count, expected busy cycles} for single-entry runs (R4, R9)
  localparam int NVEC = 6;
  localparam int VEC [NVEC][3] = '{
    '{1, 1, 2}, '{3, 2, 12}, '{0, 3, 6}, '{5, 1, 10}, '{2, 4, 16}, '{7, 3, 42}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tbl_we = 1'b0;
  logic [IDX_W-1:0]  tbl_addr = '0;
  logic [HALF_W-1:0] tbl_half = '0;
  logic [CNT_W-1:0]  tbl_count = '0;
  logic              len_we = 1'b0;
  logic [LEN_W-1:0]  len_val = '0;
  logic              start = 1'b0;
  logic              busy;
  logic              clk_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  int b_half [ENTRIES];
  int b_cnt  [ENTRIES];
  int b_len  = 0;

  always #4 clk = ~clk;

  clk_burst_seq #(.ENTRIES(ENTRIES), .HALF_W(HALF_W), .CNT_W(CNT_W)) i_clk_burst_seq (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_half(tbl_half),
    .tbl_count(tbl_count), .len_we(len_we), .len_val(len_val), .start(start),
    .busy(busy), .clk_out(clk_out)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic write_entry(input int a, input int h, input int n);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = IDX_W'(a); tbl_half = HALF_W'(h); tbl_count = CNT_W'(n);
    @(negedge clk);
    tbl_we = 1'b0;
    b_half[a] = h; b_cnt[a] = n;
  endtask

  task automatic set_len(input int l);
    @(negedge clk);
    len_we = 1'b1; len_val = LEN_W'(l);
    @(negedge clk);
    len_we = 1'b0;
    b_len = (l > ENTRIES) ? ENTRIES : l;
  endtask

  // Pulse start, then compare every busy cycle with the model of R4..R6.
  task automatic run_expect(input string req, input int mid, output int cycles);
    bit exp_q[$];
    int bad = 0;
    for (int e = 0; e < b_len; e++) begin
      if (b_cnt[e] == 0) exp_q.push_back(1'b0);
      else begin
        int he = (b_half[e] == 0) ? 1 : b_half[e];
        for (int p = 0; p < b_cnt[e]; p++)
          for (int ph = 0; ph < 2; ph++)
            for (int c = 0; c < he; c++) exp_q.push_back(ph[0]);
      end
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < exp_q.size(); k++) begin
      start = (k == mid);
      if (busy !== 1'b1 || clk_out !== exp_q[k]) bad++;
      @(negedge clk);
    end
    start = 1'b0;
    cycles = exp_q.size();
    check(bad == 0, req, "waveform mismatching cycles", bad, 0);
    check(busy === 1'b0 && clk_out === 1'b0, "R7", "end state busy/out", {busy, clk_out}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && clk_out === 1'b0, "R1", "in reset busy/out", {busy, clk_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && clk_out === 1'b0, "R1", "after reset busy/out", {busy, clk_out}, 0);

    // R2: zero entry count, start ignored
    write_entry(0, 2, 2);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    check(busy === 1'b0, "R2", "start with zero length busy", busy, 0);

    // Vector walk: single entry runs (R3, R4, R9)
    set_len(1);
    for (int v = 0; v < NVEC; v++) begin
      write_entry(0, VEC[v][0], VEC[v][1]);
      run_expect((VEC[v][0] == 0) ? "R9" : "R4", -1, cyc);
      check(cyc == VEC[v][2], "R4", "busy cycles", cyc, VEC[v][2]);
    end

    // R5/R6: back-to-back segments, empty entries in middle and at end
    write_entry(0, 2, 2);
    write_entry(1, 4, 0);
    write_entry(2, 1, 3);
    write_entry(3, 3, 1);
    write_entry(4, 9, 0);
    set_len(5);
    run_expect("R5", -1, cyc);
    check(cyc == 8 + 1 + 6 + 6 + 1, "R6", "busy cycles with empty entries", cyc, 22);

    // R6: empty entry 0
    write_entry(0, 5, 0);
    write_entry(1, 2, 1);
    set_len(2);
    run_expect("R6", -1, cyc);

    // R8: start pulse while busy
    write_entry(0, 10, 2);
    set_len(1);
    run_expect("R8", 5, cyc);
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R8", "no restart after run", busy, 0);

    // R2: length saturates at table depth
    for (int a = 0; a < ENTRIES; a++) write_entry(a, 1, (a == ENTRIES - 1) ? 1 : 0);
    set_len(127);
    run_expect("R2", -1, cyc);
    check(cyc == ENTRIES + 1, "R2", "saturated length cycles", cyc, ENTRIES + 1);

    // R1: reset during a run clears busy, output and length
    write_entry(0, 10, 2);
    set_len(1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (14) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(busy === 1'b0 && clk_out === 1'b0, "R1", "mid-run reset busy/out", {busy, clk_out}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy === 1'b0, "R1", "length cleared by reset", busy, 0);

    done = 1;
    summary();
  end

endmodule